// File: doc/BRIEF.md
# Oversampled Serial Receiver with Start Qualification

This block receives asynchronous serial characters. It is clocked by the system clock and advanced by a baud-tick enable `tick_i`, which pulses at 16 times the bit rate or, when `hs_mode_i` is set, at 8 times the bit rate. The RX line first passes through a synchronizer. A high-to-low transition on the synchronized line opens a start-qualification window of half a bit period. The start is accepted only if the line is still low when that window closes. If the line returns high on any tick inside the window, the attempt is dropped without any trace.

After a start is accepted, every later bit is sampled once per bit period, near the middle of the bit. The data bits arrive least significant first and the result is right-aligned. An optional parity bit comes next, then the stop bit. The received character is presented with a one-cycle strobe. Parity-error, framing-error and break flags come with it. The oversampling mode, character length (5 to 8 bits), parity enable and parity sense are read only when the receiver is idle, so a change made during a frame takes effect at the next start bit.

Top module: `uart_rx_core`

## Requirements
- R1: RX passes through a two-stage synchronizer. A frame begins only on a high-to-low transition of the synchronized line, so a line that simply stays low while idle starts nothing.
- R2: With `hs_mode_i`=0, a start is accepted when the synchronized line is still low on the 8th tick after the detected falling edge.
- R3: With `hs_mode_i`=1, a start is accepted when the synchronized line is still low on the 4th tick after the detected falling edge.
- R4: If the synchronized line is high on any tick of the qualification window, the receiver returns to idle with no strobe, no data and no flag. A later valid frame is still received correctly.
- R5: After an accepted start, each bit is sampled every 16 ticks (`hs_mode_i`=0) or every 8 ticks (`hs_mode_i`=1). Data bits arrive LSB first. The character is right-aligned in `data_o`, and the bits above the character length read zero.
- R6: `data_len_i` encodes the character length: 0=5, 1=6, 2=7, 3=8 data bits.
- R7: With `par_en_i`=1, a parity bit is sampled after the last data bit. `par_odd_i`=0 selects even parity and 1 selects odd parity, counted over the data bits plus the parity bit. A mismatch sets `par_err_o`. With `par_en_i`=0, `par_err_o` is 0.
- R8: A stop bit sampled low sets `frame_err_o`, and the character is still presented.
- R9: `break_o` is set when the stop bit is low and all received data bits are zero.
- R10: `valid_o` is high for exactly one cycle per received character. `data_o` and the three flags update with it and hold until the next strobe.
- R11: The mode, length and parity inputs are latched at the start edge. Changing them during a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling tick enable |
| rx_i | input | 1 | Asynchronous serial input, idle high |
| hs_mode_i | input | 1 | 0: 16x oversampling, 1: 8x oversampling |
| data_len_i | input | 2 | Character length code (0..3 = 5..8 bits) |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 0: even parity, 1: odd parity |
| data_o | output | 8 | Received character, right-aligned |
| valid_o | output | 1 | One-cycle strobe for a received character |
| par_err_o | output | 1 | Parity mismatch on the last character |
| frame_err_o | output | 1 | Stop bit sampled low on the last character |
| break_o | output | 1 | Low stop bit with all data bits zero |

## Verification
The bench builds the block with its default parameters: 16x and 8x ratios and a two-stage synchronizer. It feeds a tick every fourth clock, so one bit lasts 64 or 32 clocks. Within that timing, both qualification windows can be hit by low pulses that end before the accepting tick, and every character length and parity sense can be driven. Stop-bit faults and an extended low line after a break can also be exercised. Configuration is changed partway through one frame to show that the latched format governs that frame.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned IDX_W  = $clog2(DATA_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic rx_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[i] <= 1'b1;
        else if (i == 0) sync_q[i] <= rx_i;
        else sync_q[i] <= sync_q[(i > 0) ? i - 1 : 0];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else prev_q <= sync_q[STAGES-1];
  end

  assign rx_o   = sync_q[STAGES-1];
  assign fall_o = prev_q & ~rx_o;

  // the line must rise again before another edge
  assert_fall_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/uart_rx_os_cnt.sv
module uart_rx_os_cnt #(
  parameter int unsigned OS_HI = 16,
  parameter int unsigned OS_LO = 8,
  localparam int unsigned CNT_W = $clog2(OS_HI)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  input  logic hs_i,
  output logic half_o,
  output logic full_o
);
  localparam logic [CNT_W-1:0] HI_LAST = CNT_W'(OS_HI - 1);
  localparam logic [CNT_W-1:0] LO_LAST = CNT_W'(OS_LO - 1);
  localparam logic [CNT_W-1:0] HI_HALF = CNT_W'(OS_HI / 2 - 1);
  localparam logic [CNT_W-1:0] LO_HALF = CNT_W'(OS_LO / 2 - 1);

  logic [CNT_W-1:0] cnt_q, last, half;

  always_comb begin
    last   = hs_i ? LO_LAST : HI_LAST;
    half   = hs_i ? LO_HALF : HI_HALF;
    half_o = tick_i && (cnt_q == half);
    full_o = tick_i && (cnt_q == last);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= full_o ? '0 : cnt_q + 1'b1;
  end

  assert_cnt_in_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last);
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int unsigned OS_HI       = 16,
  parameter int unsigned OS_LO       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              hs_mode_i,
  input  logic [1:0]        data_len_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              par_err_o,
  output logic              frame_err_o,
  output logic              break_o
);
  rx_state_e         state_q;
  logic              rx_s, fall;
  logic              half_hit, full_hit, cnt_clr;
  logic [DATA_W-1:0] sh_q;
  logic [IDX_W-1:0]  idx_q, last_idx_q;
  logic              hs_q, pen_q, podd_q, par_q;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .rx_i, .rx_o(rx_s), .fall_o(fall)
  );

  assign cnt_clr = (state_q == ST_IDLE) || (state_q == ST_START && half_hit);

  uart_rx_os_cnt #(.OS_HI(OS_HI), .OS_LO(OS_LO)) u_cnt (
    .clk_i, .rst_ni, .tick_i, .clr_i(cnt_clr), .hs_i(hs_q),
    .half_o(half_hit), .full_o(full_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      sh_q        <= '0;
      idx_q       <= '0;
      last_idx_q  <= '0;
      hs_q        <= 1'b0;
      pen_q       <= 1'b0;
      podd_q      <= 1'b0;
      par_q       <= 1'b0;
      data_o      <= '0;
      valid_o     <= 1'b0;
      par_err_o   <= 1'b0;
      frame_err_o <= 1'b0;
      break_o     <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (fall) begin
          state_q    <= ST_START;
          sh_q       <= '0;
          idx_q      <= '0;
          last_idx_q <= IDX_W'(data_len_i) + IDX_W'(DATA_W - 4);
          hs_q       <= hs_mode_i;
          pen_q      <= par_en_i;
          podd_q     <= par_odd_i;
        end
        ST_START: begin
          if (tick_i && rx_s) state_q <= ST_IDLE;  // silent reject
          else if (half_hit)  state_q <= ST_DATA;
        end
        ST_DATA: if (full_hit) begin
          sh_q[idx_q] <= rx_s;
          idx_q       <= idx_q + 1'b1;
          if (idx_q == last_idx_q) state_q <= pen_q ? ST_PAR : ST_STOP;
        end
        ST_PAR: if (full_hit) begin
          par_q   <= rx_s;
          state_q <= ST_STOP;
        end
        ST_STOP: if (full_hit) begin
          data_o      <= sh_q;
          valid_o     <= 1'b1;
          par_err_o   <= pen_q & (^sh_q ^ par_q ^ podd_q);
          frame_err_o <= ~rx_s;
          break_o     <= ~rx_s & (sh_q == '0);
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_reject_silent_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && tick_i && rx_s) |=> (state_q == ST_IDLE && !valid_o));

  assert_accept_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_START && state_q == ST_DATA) |-> !$past(rx_s));

  assert_strobe_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_flags_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable({data_o, par_err_o, frame_err_o, break_o}));

  assert_break_framing_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_o |-> (frame_err_o && data_o == '0));

  assert_cfg_latched_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable({hs_q, pen_q, podd_q, last_idx_q}));
endmodule

// File: tb/uart_rx_core_bench.sv
`timescale 1ns/1ps
module uart_rx_core_bench;
  localparam int TICK_DIV = 4;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       tick = 1'b0, rx = 1'b1, hs = 1'b0, pen = 1'b0, podd = 1'b0;
  logic [1:0] dlen = 2'd3;
  logic [7:0] data;
  logic       valid, perr, ferr, brk;

  int n_chk = 0, n_fail = 0;
  int tdiv = 0;

  typedef struct {
    logic [7:0] d;
    logic       pe, fe, bk;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  always @(posedge clk) begin
    tdiv <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    tick <= (tdiv == TICK_DIV - 1);
  end

  uart_rx_core u_uart_rx_core (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rx_i(rx),
    .hs_mode_i(hs), .data_len_i(dlen), .par_en_i(pen), .par_odd_i(podd),
    .data_o(data), .valid_o(valid), .par_err_o(perr),
    .frame_err_o(ferr), .break_o(brk)
  );

  task automatic chk(input bit ok, input string what, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (q.size() == 0) begin
        chk(1'b0, "R4 strobe with nothing expected", {1'b0, perr, ferr, brk, data}, 12'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk({perr, ferr, brk, data} == {e.pe, e.fe, e.bk, e.d},
            {e.tag, " {perr,ferr,brk,data}"},
            {1'b0, perr, ferr, brk, data}, {1'b0, e.pe, e.fe, e.bk, e.d});
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive one frame; the expectation is pushed before the start bit
  task automatic send(input logic [7:0] d, input logic [1:0] len, input bit p_en,
                      input bit p_odd, input bit mode, input bit flip_par,
                      input bit stop, input bit swap, input string tag);
    int         nb = int'(len) + 5;
    int         bt = (mode ? 8 : 16) * TICK_DIV;
    logic [7:0] m  = '0;
    exp_t       e;
    for (int i = 0; i < nb; i++) m[i] = d[i];
    hs = mode; dlen = len; pen = p_en; podd = p_odd;
    wait_clk(4);
    e.d  = m;
    e.pe = p_en & flip_par;
    e.fe = ~stop;
    e.bk = ~stop & (m == 8'h00);
    e.tag = tag;
    q.push_back(e);
    rx = 1'b0;
    wait_clk(bt);
    if (swap) begin
      hs = ~mode; dlen = ~len; pen = ~p_en; podd = ~p_odd;
    end
    for (int i = 0; i < nb; i++) begin
      rx = m[i];
      wait_clk(bt);
    end
    if (p_en) begin
      rx = (^m) ^ p_odd ^ flip_par;
      wait_clk(bt);
    end
    rx = stop;
    wait_clk(bt);
    if (!stop) wait_clk(3 * bt);  // line held low after the frame: no new start
    rx = 1'b1;
    wait_clk(2 * bt);
    hs = mode; dlen = len; pen = p_en; podd = p_odd;
  endtask

  task automatic glitch(input bit mode, input int ticks_low);
    hs = mode;
    wait_clk(4);
    rx = 1'b0;
    wait_clk(ticks_low * TICK_DIV);
    rx = 1'b1;
    wait_clk(2 * (mode ? 8 : 16) * TICK_DIV);
  endtask

  initial begin
    wait_clk(5);
    chk({valid, perr, ferr, brk, data} == 12'h0, "reset outputs R10",
        {valid, perr, ferr, brk, data}, 12'h0);
    rst_n = 1'b1;
    wait_clk(20);

    send(8'hA5, 2'd3, 0, 0, 0, 0, 1, 0, "R2 R5 16x 8-bit");
    send(8'h3C, 2'd3, 0, 0, 1, 0, 1, 0, "R3 R5 8x 8-bit");
    send(8'hFF, 2'd0, 0, 0, 0, 0, 1, 0, "R6 5-bit right-aligned");
    send(8'hAA, 2'd1, 0, 0, 1, 0, 1, 0, "R6 6-bit 8x");
    send(8'h55, 2'd2, 1, 0, 0, 0, 1, 0, "R7 even parity ok");
    send(8'h81, 2'd3, 1, 1, 0, 1, 1, 0, "R7 odd parity error");
    chk(perr == 1'b1, "R10 parity flag held", {11'h0, perr}, 12'h1);
    send(8'h7E, 2'd3, 1, 1, 1, 0, 1, 0, "R7 odd parity ok 8x");
    send(8'h42, 2'd3, 0, 0, 0, 0, 0, 0, "R8 framing error");
    send(8'h00, 2'd3, 0, 0, 0, 0, 0, 0, "R9 R1 break");
    send(8'h01, 2'd3, 0, 0, 0, 0, 1, 0, "R10 flags cleared");
    glitch(0, 6);
    chk(valid == 1'b0 && q.size() == 0, "R4 16x glitch silent", {11'h0, valid}, 12'h0);
    send(8'h99, 2'd3, 0, 0, 0, 0, 1, 0, "R4 frame after 16x glitch");
    glitch(1, 2);
    chk(valid == 1'b0 && q.size() == 0, "R4 8x glitch silent", {11'h0, valid}, 12'h0);
    send(8'h66, 2'd3, 0, 0, 1, 0, 1, 0, "R4 R3 frame after 8x glitch");
    send(8'hC3, 2'd3, 0, 0, 0, 0, 1, 1, "R11 config change mid-frame");
    send(8'h5A, 2'd2, 1, 0, 1, 1, 1, 0, "R7 R6 even parity error 8x 7-bit");

    wait_clk(200);
    chk(q.size() == 0, "R10 all expected strobes seen", 12'(q.size()), 12'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule